// File: doc/BRIEF.md
# EDO DRAM Strobe Command Decoder

This block is the device side of an asynchronous 256K x 16 EDO DRAM, rebuilt at clock resolution. It watches the row strobe, the two byte-lane column strobes, write enable, output enable and the multiplexed address pins. From the order in which these edges arrive it works out what kind of cycle the controller is running. It then issues one-cycle read, write or refresh commands with byte enables to an external word array, and it drives the returned read data back onto per-lane output enables. A controller model can use it to emulate the memory, and a bus monitor can use it to check the controller.

All strobes, the address and the write data pass through the same synchronizer pipeline. Edges are found on the synchronized copies, so the decoder clock must run at least four times faster than the shortest strobe pulse. A row counter inside the block serves refreshes in which a column strobe falls before the row strobe. Two error pulses flag a row strobe held low too long and stray column strobes during precharge.

Top module: `edram_strobe_decoder`

## Requirements
- R1: While the synchronized row strobe is high, `dq_oe` is 0 from the next cycle on, and no command is issued whatever the column strobes, WE and OE do.
- R2: If either column strobe is low when the row strobe falls, the block issues one refresh command (`cmd_refresh`=1, `cmd_write`=0, `cmd_be`=0, `cmd_col`=0). Its row is the internal counter, which starts at 0 after reset and then steps by one modulo 2^ADDR_W. The address pins are ignored, and later column strobe edges under that row-low period issue nothing.
- R3: A row strobe fall with both column strobes high latches the row from `addr`. Each column pulse, which begins when one strobe falls after both were high, latches the column from `addr`. Several pulses under one row-low period each issue a command at their own column.
- R4: If WE is low when a column pulse begins, the block issues a write (`cmd_write`=1) with `cmd_wdata` taken from `din`, and `dq_oe` stays 0.
- R5: If WE is high when a column pulse begins, the block issues a read. One cycle after the read command, `dq_out` holds `rd_data` in the enabled lanes, and `dq_oe` is set for those lanes while OE is low.
- R6: Read data stays driven after the column strobes rise. It is dropped for good when the row strobe rises, when WE goes low, or when OE rises while that lane's column strobe is high. OE going high while the column strobe is low only hides the data until OE is low again.
- R7: `lcas_n` controls bits 7:0 and `cmd_be[0]`. `ucas_n` controls bits 15:8 and `cmd_be[1]`. A lane whose strobe falls after the other lane is already low issues a command for that lane alone, at the column latched by the first strobe.
- R8: If WE falls after a read in the same column pulse, while a column strobe is still low, the block issues a write to the same row and column. The write covers the lanes that are low and carries `din`.
- R9: `err_ras_long` pulses high for exactly one cycle when the synchronized row strobe has been low for RAS_MAX_CYC cycles. It lands in the same cycle as a command whose column strobe fell RAS_MAX_CYC-1 cycles after the row strobe.
- R10: `err_cas_stray` pulses for one cycle when a column strobe falls while the row strobe is high, after an earlier column pulse in the same precharge has already ended. A first fall, which can lead into a refresh, is not flagged.
- R11: Commands and error pulses come out 3 clock cycles after the pin edge that causes them: two synchronizer stages and one output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DATA_W | Write data from the data pins |
| rd_data | input | DATA_W | Word returned by the array for the current command |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_write | output | 1 | Command is a write |
| cmd_refresh | output | 1 | Command is a refresh |
| cmd_row | output | ADDR_W | Row of the command |
| cmd_col | output | ADDR_W | Column of the command |
| cmd_be | output | 2 | Byte-lane enables |
| cmd_wdata | output | DATA_W | Write data |
| dq_out | output | DATA_W | Read data for the data pins |
| dq_oe | output | 2 | Per-lane output drive enable |
| err_ras_long | output | 1 | Row strobe held low too long |
| err_cas_stray | output | 1 | Stray column strobe during precharge |

## Verification
The row-strobe timeout and the command decoder are separate pieces of logic, and both can fire in the same cycle. The bench provokes this by dropping both column strobes exactly RAS_MAX_CYC-1 cycles after the row strobe falls. The monitor records the cycle in which each event appears, and the two cycle numbers must be equal. A second check confirms that the timeout pulses only once while the row strobe stays low.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OPEN = 2'd1,
    PH_RFSH = 2'd2
  } ras_phase_t;

  localparam int LANE_COUNT = 2;

  // falling edges of active-low strobes, one bit per lane
  function automatic logic [LANE_COUNT-1:0] lane_falls(
    input logic [LANE_COUNT-1:0] prev,
    input logic [LANE_COUNT-1:0] cur
  );
    return prev & ~cur;
  endfunction

endpackage

// File: rtl/dram_sync_pipe.sv
module dram_sync_pipe #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dram_ras_timer.sv
module dram_ras_timer #(
  parameter int MAX_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic hit
);

  localparam int CW = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      hit <= 1'b0;
    end else if (!ras_low) begin
      cnt <= '0;
      hit <= 1'b0;
    end else begin
      hit <= (cnt == CW'(MAX_CYC - 1));
      if (cnt != CW'(MAX_CYC)) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dram_cas_guard.sv
module dram_cas_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_high,
  input  logic cas_fall_any,
  input  logic cas_all_high,
  output logic err
);

  logic armed;
  logic stale;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      stale <= 1'b0;
      err   <= 1'b0;
    end else if (!ras_high) begin
      armed <= 1'b0;
      stale <= 1'b0;
      err   <= 1'b0;
    end else begin
      err <= cas_fall_any & stale;
      if (cas_fall_any) begin
        armed <= 1'b1;
        stale <= 1'b0;
      end else if (armed && cas_all_high) begin
        stale <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/edram_strobe_decoder.sv
module edram_strobe_decoder
  import dram_dec_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RAS_MAX_CYC = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              lcas_n,
  input  logic              ucas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rd_data,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic              cmd_refresh,
  output logic [ADDR_W-1:0] cmd_row,
  output logic [ADDR_W-1:0] cmd_col,
  output logic [1:0]        cmd_be,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] dq_out,
  output logic [1:0]        dq_oe,
  output logic              err_ras_long,
  output logic              err_cas_stray
);

  localparam int LANE_W = DATA_W / LANE_COUNT;
  localparam int STRB_W = 5;
  localparam int BUS_W  = ADDR_W + DATA_W;

  function automatic logic [ADDR_W-1:0] next_row(input logic [ADDR_W-1:0] r);
    return r + 1'b1;
  endfunction

  // synchronized strobes {oe, we, ucas, lcas, ras} and bus
  logic [STRB_W-1:0] strb_s, strb_p;
  logic [BUS_W-1:0]  bus_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;

  dram_sync_pipe #(.W(STRB_W), .STAGES(SYNC_STAGES), .RST_VAL({STRB_W{1'b1}})) u_strb_sync (
    .clk(clk), .rst_n(rst_n), .d({oe_n, we_n, ucas_n, lcas_n, ras_n}), .q(strb_s)
  );

  dram_sync_pipe #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(bus_s)
  );

  assign addr_s = bus_s[BUS_W-1 -: ADDR_W];
  assign din_s  = bus_s[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_p <= {STRB_W{1'b1}};
    else        strb_p <= strb_s;
  end

  // named internal events
  logic       ras_s, ras_fall, we_s, we_fall, oe_s, oe_rise;
  logic [1:0] cas_s, cas_p, cas_low, lane_fall, late_fall;
  logic       cas_start, cas_idle, rd_cmd;

  assign ras_s     = strb_s[0];
  assign ras_fall  = strb_p[0] & ~strb_s[0];
  assign cas_s     = strb_s[2:1];
  assign cas_p     = strb_p[2:1];
  assign we_s      = strb_s[3];
  assign we_fall   = strb_p[3] & ~strb_s[3];
  assign oe_s      = strb_s[4];
  assign oe_rise   = ~strb_p[4] & strb_s[4];
  assign cas_low   = ~cas_s;
  assign lane_fall = lane_falls(cas_p, cas_s);
  assign cas_start = (&cas_p) & (|lane_fall);
  assign late_fall = cas_start ? 2'b00 : lane_fall;
  assign cas_idle  = &cas_s;
  assign rd_cmd    = cmd_valid & ~cmd_write & ~cmd_refresh;

  ras_phase_t        phase;
  logic [ADDR_W-1:0] row_q, col_q, ref_row;
  logic              rd_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      row_q       <= '0;
      col_q       <= '0;
      ref_row     <= '0;
      rd_pend     <= 1'b0;
      cmd_valid   <= 1'b0;
      cmd_write   <= 1'b0;
      cmd_refresh <= 1'b0;
      cmd_row     <= '0;
      cmd_col     <= '0;
      cmd_be      <= '0;
      cmd_wdata   <= '0;
    end else begin
      cmd_valid   <= 1'b0;
      cmd_write   <= 1'b0;
      cmd_refresh <= 1'b0;
      if (ras_s) begin
        phase   <= PH_IDLE;
        rd_pend <= 1'b0;
      end else if (ras_fall) begin
        rd_pend <= 1'b0;
        if (|cas_low) begin
          phase       <= PH_RFSH;
          cmd_valid   <= 1'b1;
          cmd_refresh <= 1'b1;
          cmd_row     <= ref_row;
          cmd_col     <= '0;
          cmd_be      <= '0;
          ref_row     <= next_row(ref_row);
        end else begin
          phase <= PH_OPEN;
          row_q <= addr_s;
        end
      end else if (phase == PH_OPEN) begin
        if (cas_start) begin
          col_q     <= addr_s;
          cmd_valid <= 1'b1;
          cmd_write <= ~we_s;
          cmd_row   <= row_q;
          cmd_col   <= addr_s;
          cmd_be    <= cas_low;
          cmd_wdata <= din_s;
          rd_pend   <= we_s;
        end else if (|late_fall) begin
          cmd_valid <= 1'b1;
          cmd_write <= ~we_s;
          cmd_row   <= row_q;
          cmd_col   <= col_q;
          cmd_be    <= late_fall;
          cmd_wdata <= din_s;
          rd_pend   <= rd_pend & we_s;
        end else if (we_fall && rd_pend && (|cas_low)) begin
          cmd_valid <= 1'b1;
          cmd_write <= 1'b1;
          cmd_row   <= row_q;
          cmd_col   <= col_q;
          cmd_be    <= cas_low;
          cmd_wdata <= din_s;
          rd_pend   <= 1'b0;
        end else if (cas_idle) begin
          rd_pend <= 1'b0;
        end
      end
    end
  end

  // per-lane output data hold
  logic [1:0] lane_vld;

  for (genvar gl = 0; gl < LANE_COUNT; gl++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_vld[gl]                  <= 1'b0;
        dq_out[gl*LANE_W +: LANE_W]   <= '0;
      end else if (ras_s || !we_s) begin
        lane_vld[gl] <= 1'b0;
      end else if (rd_cmd && cmd_be[gl]) begin
        lane_vld[gl]                <= 1'b1;
        dq_out[gl*LANE_W +: LANE_W] <= rd_data[gl*LANE_W +: LANE_W];
      end else if (cas_start || (oe_rise && cas_s[gl])) begin
        lane_vld[gl] <= 1'b0;
      end
    end
  end

  assign dq_oe = lane_vld & {LANE_COUNT{~oe_s}};

  dram_ras_timer #(.MAX_CYC(RAS_MAX_CYC)) u_ras_timer (
    .clk(clk), .rst_n(rst_n), .ras_low(~ras_s), .hit(err_ras_long)
  );

  dram_cas_guard u_cas_guard (
    .clk(clk), .rst_n(rst_n), .ras_high(ras_s),
    .cas_fall_any(|lane_fall), .cas_all_high(cas_idle), .err(err_cas_stray)
  );

endmodule

// File: rtl/dram_dec_checker.sv
module dram_dec_checker #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_s,
  input logic [1:0]        dq_oe,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic              cmd_refresh,
  input logic [ADDR_W-1:0] cmd_row,
  input logic [1:0]        cmd_be,
  input logic [ADDR_W-1:0] ref_row,
  input logic              err_ras_long,
  input logic              err_cas_stray
);

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ras_s) |-> dq_oe == 2'b00); // R1

  AST_CMD_NEEDS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(ras_s)); // R1

  AST_REFRESH_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_refresh) |-> (cmd_be == 2'b00 && !cmd_write)); // R2

  AST_REFRESH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_refresh) |-> ref_row == ADDR_W'(cmd_row + 1'b1)); // R2

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write) |-> dq_oe == 2'b00); // R4

  AST_LANE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_refresh) |-> cmd_be != 2'b00); // R7

  AST_RAS_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_ras_long |=> !err_ras_long); // R9

  AST_STRAY_IN_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    err_cas_stray |-> $past(ras_s)); // R10

endmodule

bind edram_strobe_decoder dram_dec_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_s(ras_s), .dq_oe(dq_oe),
  .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_refresh(cmd_refresh),
  .cmd_row(cmd_row), .cmd_be(cmd_be), .ref_row(ref_row),
  .err_ras_long(err_ras_long), .err_cas_stray(err_cas_stray)
);

// File: tb/edram_strobe_decoder_test.sv
module edram_strobe_decoder_test;

  localparam int RAS_MAX = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [8:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] rd_data;
  logic        cmd_valid, cmd_write, cmd_refresh;
  logic [8:0]  cmd_row, cmd_col;
  logic [1:0]  cmd_be, dq_oe;
  logic [15:0] cmd_wdata, dq_out;
  logic        err_ras_long, err_cas_stray;

  always #5 clk = ~clk;

  edram_strobe_decoder #(.RAS_MAX_CYC(RAS_MAX)) uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .rd_data(rd_data),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_refresh(cmd_refresh),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_be(cmd_be), .cmd_wdata(cmd_wdata),
    .dq_out(dq_out), .dq_oe(dq_oe), .err_ras_long(err_ras_long), .err_cas_stray(err_cas_stray)
  );

  // behavioural word array
  logic [15:0] mem_arr [0:1023];
  assign rd_data = mem_arr[{cmd_row[4:0], cmd_col[4:0]}];

  typedef struct packed {
    logic        wr;
    logic        rf;
    logic [8:0]  row;
    logic [8:0]  col;
    logic [1:0]  be;
    logic [15:0] wd;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0;
  int cyc = 0, cmd_cyc = -1, ras_err_cyc = -2, ras_err_n = 0, stray_n = 0, cmd_n = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (err_ras_long) begin ras_err_n++; ras_err_cyc = cyc; end
      if (err_cas_stray) stray_n++;
      if (cmd_valid) begin
        item_t got;
        cmd_n++;
        cmd_cyc = cyc;
        got = '{wr: cmd_write, rf: cmd_refresh, row: cmd_row,
                col: cmd_refresh ? 9'd0 : cmd_col, be: cmd_be,
                wd: cmd_write ? cmd_wdata : 16'h0};
        if (cmd_write) begin
          if (cmd_be[0]) mem_arr[{cmd_row[4:0], cmd_col[4:0]}][7:0]  = cmd_wdata[7:0];
          if (cmd_be[1]) mem_arr[{cmd_row[4:0], cmd_col[4:0]}][15:8] = cmd_wdata[15:8];
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected command", 64'(got), 64'h0);
        end else begin
          item_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(got == e, t, 64'(got), 64'(e));
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input bit wr, input bit rf, input logic [8:0] row, input logic [8:0] col,
                      input logic [1:0] be, input logic [15:0] wd, input string tag);
    exp_q.push_back('{wr: wr, rf: rf, row: row, col: col, be: be, wd: wd});
    tag_q.push_back(tag);
  endtask

  task automatic ras_open(input logic [8:0] row);
    addr = row; step(1);
    ras_n = 1'b0; step(4);
  endtask

  task automatic ras_close();
    ras_n = 1'b1; step(6);
  endtask

  task automatic cas_down(input logic [8:0] row, input logic [8:0] col, input logic [1:0] be,
                          input bit wr, input logic [15:0] d, input string tag);
    addr = col; din = d; we_n = ~wr; step(1);
    push(wr, 1'b0, row, col, be, wr ? d : 16'h0, tag);
    lcas_n = ~be[0]; ucas_n = ~be[1];
    step(4);
  endtask

  task automatic cas_up();
    lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; step(4);
  endtask

  task automatic do_refresh(input logic [8:0] exp_row, input string tag);
    addr = 9'h1AB;
    lcas_n = 1'b0; step(4);
    push(1'b0, 1'b1, exp_row, 9'd0, 2'b00, 16'h0, tag);
    ras_n = 1'b0; step(6);
    chk(dq_oe == 2'b00, "R2 no drive in refresh", 64'(dq_oe), 64'h0);
    ucas_n = 1'b0; lcas_n = 1'b1; step(4);  // column strobe activity ignored
    ucas_n = 1'b1; step(2);
    ras_n = 1'b1; step(6);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem_arr[i] = 16'h0;
    step(5);
    rst_n = 1'b1;
    step(2);

    // reset state
    chk(dq_oe == 2'b00 && !cmd_valid && !err_ras_long && !err_cas_stray,
        "R1 reset state", {dq_oe, cmd_valid, err_ras_long, err_cas_stray}, 64'h0);

    // early write, word
    ras_open(9'd3);
    cas_down(9'd3, 9'd5, 2'b11, 1'b1, 16'hA5C3, "R4 early write word");
    chk(dq_oe == 2'b00, "R4 no drive on write", 64'(dq_oe), 64'h0);
    cas_up();
    ras_close();

    // read with hold
    ras_open(9'd3);
    cas_down(9'd3, 9'd5, 2'b11, 1'b0, 16'h0, "R5 read word");
    chk(dq_out == 16'hA5C3, "R5 read data", 64'(dq_out), 64'hA5C3);
    chk(dq_oe == 2'b11, "R5 drive enable", 64'(dq_oe), 64'h3);
    cas_up();
    chk(dq_oe == 2'b11 && dq_out == 16'hA5C3, "R6 hold after CAS rise", {dq_oe, dq_out}, {2'b11, 16'hA5C3});
    oe_n = 1'b1; step(4);
    chk(dq_oe == 2'b00, "R6 OE rise drops data", 64'(dq_oe), 64'h0);
    oe_n = 1'b0; step(4);
    chk(dq_oe == 2'b00, "R6 dropped data stays off", 64'(dq_oe), 64'h0);
    ras_close();
    chk(dq_oe == 2'b00, "R1 idle no drive", 64'(dq_oe), 64'h0);

    // byte lanes in one page
    ras_open(9'd7);
    cas_down(9'd7, 9'd2, 2'b01, 1'b1, 16'h1234, "R7 lower lane write");
    cas_up();
    cas_down(9'd7, 9'd2, 2'b10, 1'b1, 16'hBE00, "R7 upper lane write");
    cas_up();
    cas_down(9'd7, 9'd2, 2'b11, 1'b0, 16'h0, "R3 page read");
    chk(dq_out == 16'hBE34, "R7 merged lanes", 64'(dq_out), 64'hBE34);
    cas_up();
    ras_close();

    // page mode, several columns
    ras_open(9'd9);
    cas_down(9'd9, 9'd1, 2'b11, 1'b1, 16'h1111, "R3 page write col1");
    cas_up();
    cas_down(9'd9, 9'd2, 2'b11, 1'b1, 16'h2222, "R3 page write col2");
    cas_up();
    cas_down(9'd9, 9'd1, 2'b11, 1'b0, 16'h0, "R3 page read col1");
    chk(dq_out == 16'h1111, "R3 col1 data", 64'(dq_out), 64'h1111);
    cas_up();
    cas_down(9'd9, 9'd2, 2'b11, 1'b0, 16'h0, "R3 page read col2");
    chk(dq_out == 16'h2222, "R3 col2 data", 64'(dq_out), 64'h2222);
    cas_up();
    ras_close();

    // late lane keeps first column
    ras_open(9'd9);
    cas_down(9'd9, 9'd1, 2'b01, 1'b0, 16'h0, "R7 first lane read");
    addr = 9'd20;
    push(1'b0, 1'b0, 9'd9, 9'd1, 2'b10, 16'h0, "R7 late lane read");
    ucas_n = 1'b0; step(4);
    chk(dq_out == 16'h1111 && dq_oe == 2'b11, "R7 late lane data", {dq_oe, dq_out}, {2'b11, 16'h1111});
    cas_up();
    ras_close();

    // read-modify-write
    ras_open(9'd4);
    cas_down(9'd4, 9'd6, 2'b11, 1'b1, 16'h0F0F, "R4 write before rmw");
    cas_up();
    cas_down(9'd4, 9'd6, 2'b11, 1'b0, 16'h0, "R8 rmw read");
    chk(dq_out == 16'h0F0F && dq_oe == 2'b11, "R8 old data driven", {dq_oe, dq_out}, {2'b11, 16'h0F0F});
    din = 16'h7777;
    push(1'b1, 1'b0, 9'd4, 9'd6, 2'b11, 16'h7777, "R8 rmw write");
    we_n = 1'b0; step(4);
    chk(dq_oe == 2'b00, "R6 WE low drops data", 64'(dq_oe), 64'h0);
    cas_up();
    cas_down(9'd4, 9'd6, 2'b11, 1'b0, 16'h0, "R8 readback");
    chk(dq_out == 16'h7777, "R8 new data", 64'(dq_out), 64'h7777);
    cas_up();
    ras_close();

    // refresh
    do_refresh(9'd0, "R2 refresh row 0");
    do_refresh(9'd1, "R2 refresh row 1");

    // stray column strobe in precharge
    begin
      int n0;
      n0 = cmd_n;
      lcas_n = 1'b0; step(4);
      lcas_n = 1'b1; step(4);
      chk(stray_n == 0, "R10 first fall not flagged", 64'(stray_n), 64'h0);
      lcas_n = 1'b0; step(4);
      chk(stray_n == 1, "R10 stray fall flagged", 64'(stray_n), 64'h1);
      lcas_n = 1'b1; step(4);
      chk(cmd_n == n0, "R1 no command in precharge", 64'(cmd_n), 64'(n0));
      ras_n = 1'b0; step(4);
      ras_n = 1'b1; step(6);
    end

    // RAS timeout coinciding with a command
    chk(ras_err_n == 0, "R9 no early timeout", 64'(ras_err_n), 64'h0);
    addr = 9'd2; step(1);
    ras_n = 1'b0;
    step(4);
    addr = 9'd3;
    step(RAS_MAX - 1 - 4);
    push(1'b0, 1'b0, 9'd2, 9'd3, 2'b11, 16'h0, "R9 read at timeout");
    lcas_n = 1'b0; ucas_n = 1'b0;
    step(6);
    chk(ras_err_n == 1, "R9 timeout pulse", 64'(ras_err_n), 64'h1);
    chk(ras_err_cyc == cmd_cyc, "R11 timeout and command same cycle", 64'(ras_err_cyc), 64'(cmd_cyc));
    step(60);
    chk(ras_err_n == 1, "R9 single pulse", 64'(ras_err_n), 64'h1);
    cas_up();
    ras_close();

    chk(exp_q.size() == 0, "R3 all commands seen", 64'(exp_q.size()), 64'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule